// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block sits in the master-clock domain of a serial audio port that receives its frame clock and bit clock from outside. The frame clock is derived externally from the master clock, so one frame period is a whole number of master clocks. After reset the block measures that number and decides whether the master clock runs at 256, 384 or 512 times the sample rate. The result is a two-bit ratio code that selects the internal dividers.

The frame clock is passed through a synchroniser, and its rising edges are detected. The master clocks between consecutive rising edges are counted, and each count is compared against tolerance windows. Lock is declared only when two successive periods give the same ratio. A period that fits no window raises an error flag instead.

Once locked, the ratio code is frozen until reset. A strobe generator then gives downstream logic a one-cycle sample-rate pulse aligned to the frame clock. It also gives a bit-rate pulse at 64 pulses per frame. Both pulses are derived only from the master clock, so the incoming bit clock may run at any ratio.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is asserted and right after it, `locked`, `ratio_err`, `fs_stb` and `bit_stb` are 0 and `ratio_code` is 0.
- R2: `frame_clk` passes through a two-flop synchroniser. A measurement is the number of master clocks between two consecutive synchronised rising edges. A result (lock or error) becomes visible on the outputs 3 master clocks after the `frame_clk` rise that ends the measured period.
- R3: A measurement within ±2 (inclusive) of 256, 384 or 512 is classified as ratio code 0, 1 or 2 respectively.
- R4: A measurement outside all three windows sets `ratio_err` to 1 and leaves `locked` at 0. The next in-window measurement clears `ratio_err`.
- R5: `locked` rises only when two successive measurements give the same ratio code. Two in-window measurements with different codes do not lock.
- R6: After lock, `ratio_code` and `locked` keep their values and `ratio_err` stays 0, whatever `frame_clk` does, until the next reset.
- R7: Once locked, `fs_stb` pulses for one cycle every N master clocks, where N is the detected ratio (256, 384 or 512). The first pulse comes N-1 cycles after `locked` rises. While the frame period stays at N, every pulse coincides with the synchronised rise of `frame_clk`, 2 cycles after the input rise.
- R8: Once locked, `bit_stb` pulses for one cycle every N/64 master clocks (4, 6 or 8). It pulses in every cycle where `fs_stb` pulses.
- R9: While `locked` is 0, `fs_stb` and `bit_stb` stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Frame clock at the sample rate, asynchronous sampling |
| ratio_code | output | 2 | Detected ratio: 0 = 256, 1 = 384, 2 = 512 |
| locked | output | 1 | Ratio detected and frozen |
| ratio_err | output | 1 | Last measurement before lock fitted no window |
| fs_stb | output | 1 | One-cycle sample-rate strobe |
| bit_stb | output | 1 | One-cycle bit-rate strobe (64 per frame) |

## Verification
Every result is due a fixed number of master clocks after a `frame_clk` rise. The synchroniser and edge register make the internal edge visible 2 cycles after the input rise, and `locked` or `ratio_err` changes one cycle after that, at rise+3. The bench drives `frame_clk` on falling clock edges and numbers every falling edge from the first rise. At each falling edge it samples the outputs, then drives the next input. It predicts the lock cycle, the first error cycle and the exact cycle of each strobe from the programmed frame periods, and compares them with what it sees. Strobe timing is checked in every cycle of a scenario, so an early, late or missing pulse counts as a mismatch.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
   typedef enum logic [1:0] {
      RATIO_LO   = 2'd0,
      RATIO_MID  = 2'd1,
      RATIO_HI   = 2'd2,
      RATIO_NONE = 2'd3
   } ratio_e;

   localparam int unsigned NUM_RATIOS = 3;
endpackage

// File: rtl/mrd_frame_sync.sv
module mrd_frame_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_i,
   output logic rise_o
);
   initial begin
      assert (STAGES >= 2) else $error("mrd_frame_sync: STAGES must be at least 2");
   end

   // chain[0..STAGES-1] synchronise, chain[STAGES] holds the previous synced value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], frame_i};
   end

   assign rise_o = chain[STAGES-1] & ~chain[STAGES];

   // R2
   edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/mrd_period_meas.sv
module mrd_period_meas #(
   parameter int unsigned CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   output logic             meas_vld_o,
   output logic [CNT_W-1:0] meas_cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (rise_i) begin
         cnt_q   <= CNT_ONE;
         armed_q <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q   <= cnt_q + CNT_ONE;
      end
   end

   assign meas_vld_o = rise_i & armed_q;
   assign meas_cnt_o = cnt_q;

   // R2
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_i |=> (cnt_q == CNT_ONE) && armed_q);
endmodule

// File: rtl/mrd_classify.sv
module mrd_classify
   import mrd_pkg::*;
#(
   parameter int unsigned CNT_W = 11,
   parameter int unsigned R_LO  = 256,
   parameter int unsigned R_MID = 384,
   parameter int unsigned R_HI  = 512,
   parameter int unsigned TOL   = 2
) (
   input  logic [CNT_W-1:0] count_i,
   output logic             valid_o,
   output ratio_e           code_o
);
   localparam int unsigned RTAB [NUM_RATIOS] = '{R_LO, R_MID, R_HI};

   logic [NUM_RATIOS-1:0] hit;

   for (genvar gi = 0; gi < NUM_RATIOS; gi++) begin : g_win
      localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(RTAB[gi] - TOL);
      localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(RTAB[gi] + TOL);
      assign hit[gi] = (count_i >= WIN_LO) && (count_i <= WIN_HI);
   end

   always_comb begin
      valid_o = |hit;
      if (hit[0])      code_o = RATIO_LO;
      else if (hit[1]) code_o = RATIO_MID;
      else if (hit[2]) code_o = RATIO_HI;
      else             code_o = RATIO_NONE;
   end
endmodule

// File: rtl/mrd_strobe_gen.sv
module mrd_strobe_gen
   import mrd_pkg::*;
#(
   parameter int unsigned R_LO  = 256,
   parameter int unsigned R_MID = 384,
   parameter int unsigned R_HI  = 512,
   parameter int unsigned BPF   = 64
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   input  logic   run_i,
   input  ratio_e code_i,
   output logic   fs_stb_o,
   output logic   bit_stb_o
);
   localparam int unsigned PH_W = $clog2(R_HI);

   logic [PH_W-1:0] ph_q, bc_q, ph_last, bc_last;
   logic            ph_wrap;

   always_comb begin
      case (code_i)
         RATIO_MID: begin ph_last = PH_W'(R_MID - 1); bc_last = PH_W'(R_MID / BPF - 1); end
         RATIO_HI:  begin ph_last = PH_W'(R_HI - 1);  bc_last = PH_W'(R_HI / BPF - 1);  end
         default:   begin ph_last = PH_W'(R_LO - 1);  bc_last = PH_W'(R_LO / BPF - 1);  end
      endcase
   end

   assign ph_wrap = (ph_q == ph_last);

   // phase 0 corresponds to the cycle of the synchronised frame rise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
         bc_q <= '0;
      end else if (start_i) begin
         ph_q <= PH_W'(1);
         bc_q <= PH_W'(1);
      end else if (run_i) begin
         ph_q <= ph_wrap ? '0 : ph_q + PH_W'(1);
         bc_q <= (ph_wrap || bc_q == bc_last) ? '0 : bc_q + PH_W'(1);
      end
   end

   assign fs_stb_o  = run_i && (ph_q == '0);
   assign bit_stb_o = run_i && (bc_q == '0);

   // R8
   bit_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs_stb_o |-> bit_stb_o);

   // R9
   quiet_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |-> !fs_stb_o && !bit_stb_o);

   // R7
   fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs_stb_o |=> !fs_stb_o);
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
   import mrd_pkg::*;
#(
   parameter int unsigned R_LO        = 256,
   parameter int unsigned R_MID       = 384,
   parameter int unsigned R_HI        = 512,
   parameter int unsigned TOL         = 2,
   parameter int unsigned BPF         = 64,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_clk,
   output logic [1:0] ratio_code,
   output logic       locked,
   output logic       ratio_err,
   output logic       fs_stb,
   output logic       bit_stb
);
   localparam int unsigned CNT_W = $clog2(R_HI + TOL + 1) + 1;

   initial begin
      assert (R_LO + 2 * TOL < R_MID && R_MID + 2 * TOL < R_HI)
         else $error("mclk_ratio_detect: ratio windows overlap or are unordered");
      assert (TOL < R_LO) else $error("mclk_ratio_detect: TOL too large");
      assert (R_LO % BPF == 0 && R_MID % BPF == 0 && R_HI % BPF == 0)
         else $error("mclk_ratio_detect: ratios must be multiples of BPF");
      assert (R_LO / BPF >= 2) else $error("mclk_ratio_detect: bit divider below 2");
   end

   logic             rise;
   logic             meas_vld;
   logic [CNT_W-1:0] meas_cnt;
   logic             cls_valid;
   ratio_e           cls_code;
   logic             lock_set;

   ratio_e ratio_q, cand_q;
   logic   have_cand_q, locked_q, err_q;

   mrd_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_clk), .rise_o(rise));

   mrd_period_meas #(.CNT_W(CNT_W)) u_meas (
      .clk(clk), .rst_n(rst_n), .rise_i(rise),
      .meas_vld_o(meas_vld), .meas_cnt_o(meas_cnt));

   mrd_classify #(.CNT_W(CNT_W), .R_LO(R_LO), .R_MID(R_MID), .R_HI(R_HI), .TOL(TOL)) u_cls (
      .count_i(meas_cnt), .valid_o(cls_valid), .code_o(cls_code));

   assign lock_set = meas_vld && !locked_q && cls_valid && have_cand_q && (cand_q == cls_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q     <= RATIO_LO;
         cand_q      <= RATIO_LO;
         have_cand_q <= 1'b0;
         locked_q    <= 1'b0;
         err_q       <= 1'b0;
      end else if (meas_vld && !locked_q) begin
         if (!cls_valid) begin
            err_q       <= 1'b1;
            have_cand_q <= 1'b0;
         end else begin
            err_q       <= 1'b0;
            have_cand_q <= 1'b1;
            cand_q      <= cls_code;
            if (lock_set) begin
               locked_q <= 1'b1;
               ratio_q  <= cls_code;
            end
         end
      end
   end

   mrd_strobe_gen #(.R_LO(R_LO), .R_MID(R_MID), .R_HI(R_HI), .BPF(BPF)) u_stb (
      .clk(clk), .rst_n(rst_n), .start_i(lock_set), .run_i(locked_q),
      .code_i(ratio_q), .fs_stb_o(fs_stb), .bit_stb_o(bit_stb));

   assign ratio_code = ratio_q;
   assign locked     = locked_q;
   assign ratio_err  = err_q;

   // R4
   lock_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |-> !err_q);

   // R6
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(locked_q) |-> locked_q && $stable(ratio_q));

   // R3
   code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |-> ratio_q != RATIO_NONE);

   // R5
   lock_on_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> $past(meas_vld));
endmodule

// File: tb/tb_mclk_ratio_detect.sv
module tb_mclk_ratio_detect;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_clk = 1'b0;
   logic [1:0] ratio_code;
   logic       locked, ratio_err, fs_stb, bit_stb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // per-scenario observations
   int locked_at, err_first, fs_cnt, bit_cnt, fs_mis, bit_mis;
   bit err_seen;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mclk_ratio_detect dut (
      .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
      .ratio_code(ratio_code), .locked(locked), .ratio_err(ratio_err),
      .fs_stb(fs_stb), .bit_stb(bit_stb));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic do_reset();
      frame_clk = 1'b0;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Drive frame periods p0,p1,p2 then pn; rise k is driven at falling edge k-index.
   // Outputs are sampled at each falling edge before the input is updated.
   task automatic drive(input int p0, input int p1, input int p2, input int pn,
                        input int ncyc, input int model_ratio);
      int next_rise = 0;
      int hi_end = -1;
      int k = 0;
      locked_at = -1; err_first = -1; fs_cnt = 0; bit_cnt = 0;
      fs_mis = 0; bit_mis = 0; err_seen = 1'b0;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         if (locked && locked_at < 0) locked_at = c;
         if (ratio_err) begin
            err_seen = 1'b1;
            if (err_first < 0) err_first = c;
         end
         if (fs_stb) fs_cnt++;
         if (bit_stb) bit_cnt++;
         if (model_ratio > 0) begin
            bit exp_fs, exp_bit;
            exp_fs  = (c >= 3 * model_ratio + 2) && ((c - 2) % model_ratio == 0);
            exp_bit = (c >= 2 * model_ratio + 3) && ((c - 2) % (model_ratio / 64) == 0);
            if (fs_stb != exp_fs) fs_mis++;
            if (bit_stb != exp_bit) bit_mis++;
         end
         if (c == next_rise) begin
            int per;
            per = (k == 0) ? p0 : (k == 1) ? p1 : (k == 2) ? p2 : pn;
            frame_clk = 1'b1;
            hi_end = c + per / 2;
            next_rise = c + per;
            k++;
         end else if (c == hi_end) begin
            frame_clk = 1'b0;
         end
      end
   endtask

   task automatic t_reset_state();
      do_reset();
      @(negedge clk);
      check(locked == 1'b0, "R1", "locked after reset", locked, 0);
      check(ratio_err == 1'b0, "R1", "ratio_err after reset", ratio_err, 0);
      check(ratio_code == 2'd0, "R1", "ratio_code after reset", ratio_code, 0);
      check(fs_stb == 1'b0, "R1", "fs_stb after reset", fs_stb, 0);
      check(bit_stb == 1'b0, "R1", "bit_stb after reset", bit_stb, 0);
   endtask

   task automatic t_exact(input int ratio, input int code);
      do_reset();
      drive(ratio, ratio, ratio, ratio, 7 * ratio, ratio);
      check(locked_at == 2 * ratio + 3, "R2", "lock cycle", locked_at, 2 * ratio + 3);
      check(ratio_code == 2'(code), "R3", "ratio code", ratio_code, code);
      check(!err_seen, "R4", "no error on in-window periods", err_seen, 0);
      check(fs_mis == 0 && fs_cnt > 0, "R7", "fs_stb timing mismatches", fs_mis, 0);
      check(bit_mis == 0 && bit_cnt > fs_cnt, "R8", "bit_stb timing mismatches", bit_mis, 0);
   endtask

   task automatic t_tolerance();
      do_reset();
      drive(258, 254, 254, 256, 1500, 0);
      check(locked_at == 258 + 254 + 3, "R3", "lock at +2/-2 of 256", locked_at, 515);
      check(ratio_code == 2'd0, "R3", "code for 256 window", ratio_code, 0);
      do_reset();
      drive(514, 510, 510, 512, 1500, 0);
      check(locked_at == 514 + 510 + 3, "R3", "lock at +2/-2 of 512", locked_at, 1027);
      check(ratio_code == 2'd2, "R3", "code for 512 window", ratio_code, 2);
   endtask

   task automatic t_out_of_window(input int per);
      do_reset();
      drive(per, per, per, per, 6 * per, 0);
      check(err_first == per + 3, "R4", "error cycle for out-of-window period", err_first, per + 3);
      check(locked_at == -1, "R4", "no lock on out-of-window period", locked_at, -1);
      check(fs_cnt == 0 && bit_cnt == 0, "R9", "no strobes while unlocked", fs_cnt + bit_cnt, 0);
   endtask

   task automatic t_mismatch();
      do_reset();
      drive(256, 384, 384, 384, 2000, 0);
      check(locked_at == 256 + 384 + 384 + 3, "R5", "lock waits for matching pair", locked_at, 1027);
      check(ratio_code == 2'd1, "R5", "code after matching 384 pair", ratio_code, 1);
   endtask

   task automatic t_freeze();
      do_reset();
      drive(256, 256, 256, 512, 4000, 256);
      check(locked == 1'b1, "R6", "lock held after frame rate change", locked, 1);
      check(ratio_code == 2'd0, "R6", "code frozen after frame rate change", ratio_code, 0);
      check(!err_seen, "R6", "no error after lock", err_seen, 0);
      check(fs_mis == 0, "R6", "fs_stb keeps locked period", fs_mis, 0);
   endtask

   task automatic t_recover();
      do_reset();
      drive(300, 256, 256, 256, 1500, 0);
      check(err_first == 303, "R4", "error on first bad period", err_first, 303);
      check(ratio_err == 1'b0, "R4", "error cleared by good period", ratio_err, 0);
      check(locked_at == 300 + 256 + 256 + 3, "R5", "lock after recovery", locked_at, 815);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_exact(256, 0);
      t_exact(384, 1);
      t_exact(512, 2);
      t_tolerance();
      t_out_of_window(259);
      t_out_of_window(381);
      t_mismatch();
      t_freeze();
      t_recover();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule